// File: doc/BRIEF.md
# Serial Configuration Register Slave with Indexed Block Transfers

This block is a two-wire serial slave that sits on SMBus-style SCL/SDA lines and fronts a bank of thirteen 8-bit configuration bytes. Both lines are oversampled by the system clock. Start and stop conditions are found as SDA edges while SCL is high. The slave pulls SDA low only through an open-drain enable, and only while SCL is low.

A host write names a starting index and a byte count, then streams that many bytes into consecutive locations. A host read names an index, issues a repeated start with the read address, and receives first a count byte and then the bank contents from that index onward, until it answers a byte with NAK. Byte 7 is a fixed identification byte. Bytes 11 and 12 hold two divider fields and accept writes only while bit 7 of byte 10 is set. The whole bank and the decoded divider values are presented as outputs for the clock logic that uses them.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the slave leaves SDA released until the next start.
- R2: In a write, the index byte and the count byte are each acknowledged. The following data bytes are stored at index, index+1, and onward, and each one is acknowledged.
- R3: In a write, a data byte sent after the count has been used up is not acknowledged and is not stored. A count of 0 therefore refuses the first data byte.
- R4: In a read, the first byte the slave returns is the current content of byte 8. The bank bytes follow, starting at the index given before the repeated start.
- R5: After reset: byte 1 = 0xFF, byte 2 = 0x3F, byte 5 = 0x8F, byte 6 = 0xFF, byte 7 = 0x21, byte 8 = 0x08, byte 9 = 0xFF, and every other byte = 0x00. `cfg_o` carries byte i in bits 8i+7..8i.
- R6: Byte 7 always reads 0x21. A write to it is acknowledged and has no effect.
- R7: Bytes 11 and 12 change on a write only while bit 7 of byte 10 is 1. Otherwise the write is acknowledged and discarded.
- R8: `fb_div_o` equals {byte 11 bit 7, byte 12}, and `ref_div_o` equals byte 11 bits 6..0.
- R9: After each data byte, the index advances by one but stops at 12. An index above 12 discards writes and reads back 0x00.
- R10: SDA pull-down changes only while SCL is low and is off whenever the slave is idle. A stop returns the slave to idle.
- R11: When the host answers a read byte with NAK, the slave releases SDA and sends nothing more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_o | output | 104 | All configuration bytes, byte i at bits 8i+7..8i |
| ref_div_o | output | 7 | Reference divider field |
| fb_div_o | output | 9 | Feedback divider field |

## Verification
On the eighth SCL rise of a data byte, the slave stores the byte and moves the index forward in the same cycle. At the top of the bank, that same cycle must both store into byte 12 and hold the index at 12. A burst from index 11 with count 3 provokes this. The cycle-by-cycle model of the bank must then show the first byte in byte 11 and the third byte, not the second, in byte 12. A second coincidence is the protected write decision against the gate bit. The gate is opened and closed by separate transfers, and bytes 11 and 12 are compared on every clock after each transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACKW,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_INDEX,
    RL_COUNT,
    RL_DATA
  } role_e;

  // Power-on content of each configuration byte
  function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h3F;
      5:       return 8'h8F;
      6:       return 8'hFF;
      7:       return 8'h21;
      8:       return 8'h08;
      9:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 13,
  parameter int unsigned RO_IDX    = 7,
  parameter int unsigned GATE_IDX  = 10,
  parameter int unsigned GATE_BIT  = 7,
  parameter int unsigned PROT_LO   = 11,
  parameter int unsigned PROT_HI   = 12,
  localparam int unsigned FLAT_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [FLAT_W-1:0] bank_o
);

  logic gate_on;
  assign gate_on = bank_o[GATE_IDX*BYTE_W + GATE_BIT];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    localparam logic [BYTE_W-1:0] RST = reset_byte(g);
    logic              hit, allow;
    logic [BYTE_W-1:0] q, d;

    assign hit = wr_en && (wr_idx == BYTE_W'(g));

    if (g == RO_IDX) begin : g_ro
      assign allow = 1'b0;
    end else if (g >= PROT_LO && g <= PROT_HI) begin : g_prot
      assign allow = gate_on;
    end else begin : g_rw
      assign allow = 1'b1;
    end

    always_comb begin
      d = q;
      if (hit && allow) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= d;
    end

    assign bank_o[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rd_idx == BYTE_W'(i)) rd_data = bank_o[i*BYTE_W +: BYTE_W];
    end
  end

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == BYTE_W'(RO_IDX)) |=> $stable(bank_o[RO_IDX*BYTE_W +: BYTE_W])); // R6

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == BYTE_W'(PROT_HI) && !gate_on) |=> $stable(bank_o[PROT_HI*BYTE_W +: BYTE_W])); // R7

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NUM_BYTES   = 13,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned COUNT_IDX   = 8,
  parameter int unsigned RO_IDX      = 7,
  parameter int unsigned GATE_IDX    = 10,
  parameter int unsigned GATE_BIT    = 7,
  parameter int unsigned PROT_LO     = 11,
  parameter int unsigned PROT_HI     = 12,
  localparam int unsigned FLAT_W     = NUM_BYTES * BYTE_W,
  localparam int unsigned LAST_IDX   = NUM_BYTES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [FLAT_W-1:0] cfg_o,
  output logic [6:0]        ref_div_o,
  output logic [8:0]        fb_div_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  phase_e            phase_q, phase_d;
  role_e             role_q, role_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] idx_q, idx_d, rem_q, rem_d, tx_q, tx_d;
  logic              ack_q, ack_d, rdm_q, rdm_d, pull_q, pull_d;
  logic              wr_en;
  logic [BYTE_W-1:0] rx_byte, idx_inc, rd_data, cnt_byte;

  smb_reg_bank #(
    .NUM_BYTES (NUM_BYTES),
    .RO_IDX    (RO_IDX),
    .GATE_IDX  (GATE_IDX),
    .GATE_BIT  (GATE_BIT),
    .PROT_LO   (PROT_LO),
    .PROT_HI   (PROT_HI)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (idx_q),
    .wr_data (rx_byte),
    .rd_idx  (idx_q),
    .rd_data (rd_data),
    .bank_o  (cfg_o)
  );

  assign rx_byte  = {tx_q[6:0], sda_s};
  assign idx_inc  = (idx_q < BYTE_W'(LAST_IDX)) ? idx_q + 8'd1 : idx_q;
  assign cnt_byte = cfg_o[COUNT_IDX*BYTE_W +: BYTE_W];

  always_comb begin
    phase_d = phase_q;
    role_d  = role_q;
    bit_d   = bit_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    tx_d    = tx_q;
    ack_d   = ack_q;
    rdm_d   = rdm_q;
    pull_d  = pull_q;
    wr_en   = 1'b0;
    if (stop_c) begin
      phase_d = PH_IDLE;
      pull_d  = 1'b0;
    end else if (start_c) begin
      phase_d = PH_RX;
      role_d  = RL_ADDR;
      bit_d   = '0;
      pull_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_RX: if (scl_rise) begin
          tx_d  = rx_byte;
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            phase_d = PH_RX_ACKW;
            ack_d   = 1'b0;
            rdm_d   = 1'b0;
            case (role_q)
              RL_ADDR: if (rx_byte[7:1] == DEV_ADDR) begin
                ack_d  = 1'b1;
                rdm_d  = rx_byte[0];
                role_d = RL_INDEX;
              end
              RL_INDEX: begin
                ack_d  = 1'b1;
                idx_d  = rx_byte;
                role_d = RL_COUNT;
              end
              RL_COUNT: begin
                ack_d  = 1'b1;
                rem_d  = rx_byte;
                role_d = RL_DATA;
              end
              default: if (rem_q != '0) begin
                ack_d = 1'b1;
                wr_en = 1'b1;
                rem_d = rem_q - 8'd1;
                idx_d = idx_inc;
              end
            endcase
          end
        end
        PH_RX_ACKW: if (scl_fall) begin
          if (ack_q) begin
            pull_d  = 1'b1;
            phase_d = PH_RX_ACK;
          end else begin
            phase_d = PH_IDLE;
          end
        end
        PH_RX_ACK: if (scl_fall) begin
          bit_d = '0;
          if (rdm_q) begin
            phase_d = PH_TX;
            tx_d    = cnt_byte;
            pull_d  = ~cnt_byte[7];
          end else begin
            phase_d = PH_RX;
            pull_d  = 1'b0;
          end
        end
        PH_TX: if (scl_fall) begin
          if (bit_q == 3'd7) begin
            pull_d  = 1'b0;
            ack_d   = 1'b0;
            phase_d = PH_TX_ACK;
          end else begin
            tx_d   = {tx_q[6:0], 1'b0};
            pull_d = ~tx_q[6];
            bit_d  = bit_q + 3'd1;
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) ack_d = ~sda_s;
          if (scl_fall) begin
            if (ack_q) begin
              phase_d = PH_TX;
              bit_d   = '0;
              tx_d    = rd_data;
              pull_d  = ~rd_data[7];
              idx_d   = idx_inc;
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      role_q  <= RL_ADDR;
      bit_q   <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      tx_q    <= '0;
      ack_q   <= 1'b0;
      rdm_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      role_q  <= role_d;
      bit_q   <= bit_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      tx_q    <= tx_d;
      ack_q   <= ack_d;
      rdm_q   <= rdm_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign ref_div_o  = cfg_o[PROT_LO*BYTE_W +: 7];
  assign fb_div_o   = {cfg_o[PROT_LO*BYTE_W + 7], cfg_o[PROT_HI*BYTE_W +: BYTE_W]};

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(pull_q) |-> !scl_s); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_IDLE) |-> !pull_q); // R10

  AST_NAK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_TX_ACK && scl_fall && !ack_q && !start_c && !stop_c) |=> (phase_q == PH_IDLE && !pull_q)); // R11

  AST_NO_WRITE_PAST_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_RX_ACKW && role_q == RL_DATA && !ack_q) |-> $stable(cfg_o)); // R3

endmodule

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;

  localparam int NB = 13;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic host_scl = 1'b1;
  logic host_low = 1'b0;
  logic dut_pull;
  logic sda_line;
  logic [NB*8-1:0] cfg;
  logic [6:0] refd;
  logic [8:0] fbd;

  assign sda_line = ~(host_low | dut_pull);

  smb_cfg_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (host_scl),
    .sda_i      (sda_line),
    .sda_pull_o (dut_pull),
    .cfg_o      (cfg),
    .ref_div_o  (refd),
    .fb_div_o   (fbd)
  );

  int mdl[NB];
  int errors = 0;
  int checks = 0;
  bit quiet = 1'b0;

  function automatic void chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic void mdl_write(int idx, int val);
    if (idx < NB && idx != 7 && !((idx == 11 || idx == 12) && mdl[10][7] == 1'b0))
      mdl[idx] = val;
  endfunction

  function automatic int adv(int idx);
    return (idx < NB-1) ? idx + 1 : idx;
  endfunction

  // Reference model compared against the bank on every quiet clock
  always @(negedge clk) begin
    if (quiet && rst_n) begin
      logic [NB*8-1:0] exp_flat;
      for (int i = 0; i < NB; i++) exp_flat[i*8 +: 8] = 8'(mdl[i]);
      checks++;
      if (cfg !== exp_flat) begin
        errors++;
        $display("FAIL R2 R5 R6 R7 R9 bank actual=%h expected=%h", cfg, exp_flat);
      end
      chk("R8 feedback divider", int'(fbd), {mdl[11][7], mdl[12][7:0]});
      chk("R8 reference divider", int'(refd), mdl[11][6:0]);
    end
  end

  // Pull-down may only change while SCL is low
  logic prev_pull = 1'b0;
  logic prev_scl  = 1'b1;
  always @(negedge clk) begin
    if (rst_n && dut_pull !== prev_pull) begin
      chk("R10 pull changed with SCL high", int'(prev_scl & host_scl), 0);
    end
    prev_pull <= dut_pull;
    prev_scl  <= host_scl;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_low = 1'b1; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; tick(Q);
      host_scl = 1'b1;  tick(2*Q);
      host_scl = 1'b0;  tick(2);
    end
    host_low = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    host_scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit nak, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      host_scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      host_scl = 1'b0; tick(2);
    end
    host_low = ~nak; tick(Q);
    host_scl = 1'b1; tick(2*Q);
    host_scl = 1'b0; tick(2);
    host_low = 1'b0;
  endtask

  task automatic wr_block(input int idx, input int cnt, input int data[$]);
    bit a;
    int pos, rem;
    quiet = 1'b0;
    bus_start();
    send_byte(8'hD2, a);        chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);      chk("R2 index ack", a, 1);
    send_byte(8'(cnt), a);      chk("R2 count ack", a, 1);
    pos = idx;
    rem = cnt;
    foreach (data[k]) begin
      send_byte(8'(data[k]), a);
      if (rem > 0) begin
        chk("R2 data ack", a, 1);
        mdl_write(pos, data[k]);
        pos = adv(pos);
        rem--;
      end else begin
        chk("R3 byte past count refused", a, 0);
        break;
      end
    end
    bus_stop();
    tick(8);
    quiet = 1'b1;
    tick(4);
  endtask

  task automatic rd_block(input int idx, input int n);
    bit a;
    logic [7:0] b;
    int pos;
    quiet = 1'b0;
    bus_start();
    send_byte(8'hD2, a);        chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);      chk("R4 index ack", a, 1);
    bus_start();
    send_byte(8'hD3, a);        chk("R1 read address ack", a, 1);
    recv_byte(n == 0, b);       chk("R4 count byte", int'(b), mdl[8]);
    pos = idx;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n-1, b);
      chk("R4 R9 read data", int'(b), (pos < NB) ? mdl[pos] : 0);
      pos = adv(pos);
    end
    tick(Q);
    chk("R11 SDA released after NAK", int'(sda_line), 1);
    bus_stop();
    tick(8);
    quiet = 1'b1;
    tick(4);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    summary();
  end

  initial begin
    bit a;
    for (int i = 0; i < NB; i++) mdl[i] = 0;
    mdl[1] = 'hFF; mdl[2] = 'h3F; mdl[5] = 'h8F; mdl[6] = 'hFF;
    mdl[7] = 'h21; mdl[8] = 'h08; mdl[9] = 'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    quiet = 1'b1;
    chk("R5 reset byte 1", int'(cfg[1*8 +: 8]), 'hFF);
    chk("R5 reset byte 5", int'(cfg[5*8 +: 8]), 'h8F);
    chk("R5 reset byte 8", int'(cfg[8*8 +: 8]), 'h08);
    chk("R10 released after reset", int'(sda_line), 1);
    tick(20);

    rd_block(0, 8);
    wr_block(1, 3, '{'hA5, 'h5A, 'hC3});
    wr_block(7, 1, '{'h00});
    chk("R6 byte 7 after write", int'(cfg[7*8 +: 8]), 'h21);
    wr_block(11, 2, '{'h9A, 'h34});
    chk("R7 byte 11 gated off", int'(cfg[11*8 +: 8]), 'h00);
    wr_block(10, 1, '{'h80});
    wr_block(11, 2, '{'h9A, 'h34});
    chk("R8 feedback value", int'(fbd), 'h134);
    chk("R8 reference value", int'(refd), 'h1A);
    wr_block(3, 1, '{'h11, 'h22});
    chk("R3 byte 4 untouched", int'(cfg[4*8 +: 8]), 'h00);
    wr_block(4, 0, '{'h77});
    wr_block(11, 3, '{'h01, 'h02, 'h03});
    chk("R9 byte 12 holds last", int'(cfg[12*8 +: 8]), 'h03);
    wr_block(8, 1, '{'h03});
    rd_block(10, 3);
    rd_block(20, 2);
    wr_block(20, 1, '{'h5E});
    rd_block(0, 0);
    wr_block(10, 1, '{'h00});
    wr_block(12, 1, '{'h55});
    chk("R7 byte 12 gated off", int'(cfg[12*8 +: 8]), 'h03);

    quiet = 1'b0;
    bus_start();
    send_byte(8'hA0, a);   chk("R1 foreign address refused", a, 0);
    send_byte(8'hD2, a);   chk("R1 ignored until next start", a, 0);
    bus_stop();
    tick(8);
    quiet = 1'b1;
    chk("R10 idle after stop", int'(sda_line), 1);
    rd_block(1, 2);
    tick(20);
    summary();
  end

endmodule